// File: doc/BRIEF.md
# Masked-Flag Eight-Bit ALU

This is a purely combinational arithmetic and logic unit for a small accumulator-style processor. It takes two operands, a four-bit operation code and the current eight-bit flag register. It returns an eight-bit result, a write-back enable and the next value of the flag register. Every operation first forms a double-width (sixteen-bit) intermediate value. The zero, carry, overflow and sign conditions are all derived from that one value.

Each operation class owns a fixed subset of the flags. The block merges the freshly computed conditions into the incoming flag register through a per-operation mask, so every flag outside that subset leaves the block exactly as it entered. Compare and bit-test only affect flags and lower the write-back enable. Shifts, rotates and the bit test take their amount or bit index from the three low bits of the second operand and ignore its upper bits.

The surrounding datapath owns the register file, decode and memory. It presents operands and flags, then captures the result when the write-back enable is high and always captures the returned flags.

Top module: `alu8_core`

## Requirements
- R1: Flag positions are Z=bit0, C=bit1, O=bit2, S=bit3, I=bit4, B=bit5. Bits 4 to 7 of the flag output always equal those of the flag input.
- R2: Codes 0 (AND), 1 (OR) and 2 (XOR) return the bitwise result of A and B. They update only Z and S, and C and O pass through.
- R3: Codes 3 (ADD, A+B) and 6 (INC, A+1, B ignored) return the low byte of the sum. C and O are both set when the sum exceeds 0xFF and both cleared otherwise.
- R4: Codes 4 (SUB, A-B) and 7 (DEC, A-1, B ignored) return the low byte of the difference. A borrow wraps into the high byte and sets both C and O.
- R5: Code 5 (CMP) sets all four of Z, C, O and S exactly as SUB does and drives the write-back enable low.
- R6: For every operation that updates Z, Z is 1 exactly when the low byte of the intermediate is zero, except for the bit test (R10). For every operation that updates S, S equals bit 7 of the result.
- R7: Codes 8 (SHL) and 9 (SHR) shift A by B[2:0] with zero fill and ignore B[7:3]. They update Z, C and S and keep O. C for SHL is set when any 1 is shifted out of the top. SHR always clears C.
- R8: Code 10 (ROL) rotates A left by B[2:0] and keeps O. C is set when the n bits carried from the top to the bottom include a 1. A count of 0 returns A unchanged with C cleared.
- R9: Code 11 (ROR) rotates A right by n=B[2:0] and keeps O. C is set when A shifted right by n is nonzero, so a count of 0 returns A unchanged and sets C whenever A is nonzero.
- R10: Code 12 (BIT) sets Z when bit B[2:0] of A is 0 and clears Z when it is 1. It leaves every other flag unchanged, returns A as the result and drives the write-back enable low.
- R11: Codes 13 to 15 are unassigned. For these codes the flag output equals the flag input, the result is 0 and the write-back enable is low.
- R12: The write-back enable is high for codes 0 to 4 and 6 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand, the value operated on |
| opnd_b | input | 8 | Second operand; its low 3 bits are the count or bit index for shifts, rotates and BIT |
| flags_in | input | 8 | Current flag register |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | High when the result should be written back |
| flags_o | output | 8 | Next flag register value |

## Verification
A vector table drives each operation with operand pairs chosen to separate the flag conditions. One pair lands exactly on zero, another crosses 0xFF and another borrows. Each vector also uses a flag input whose untouched bits are deliberately nonzero, so a wrong mask shows up as a changed pass-through bit. Shift and rotate vectors put garbage in the upper bits of the count and use counts of zero, which tell the carry-out rules of ROL and ROR apart. Directed sweeps then walk every rotate count and every tested bit index, and all sixteen operation codes for the write-back enable and the unassigned-code behaviour.

// File: rtl/alu8_pkg.sv
// Package: operation codes, flag bit positions and per-operation flag masks
// shared by the ALU and its checker. Assumes an 8-bit flag register.
package alu8_pkg;

    localparam int FLAG_W = 8;
    localparam int FLAG_Z = 0;
    localparam int FLAG_C = 1;
    localparam int FLAG_O = 2;
    localparam int FLAG_S = 3;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_OR  = 4'd1,  OP_XOR = 4'd2,  OP_ADD = 4'd3,
        OP_SUB = 4'd4,  OP_CMP = 4'd5,  OP_INC = 4'd6,  OP_DEC = 4'd7,
        OP_SHL = 4'd8,  OP_SHR = 4'd9,  OP_ROL = 4'd10, OP_ROR = 4'd11,
        OP_BIT = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_NONE, CLS_LOGIC, CLS_ARITH, CLS_SHIFT
    } alu_cls_e;

    localparam logic [FLAG_W-1:0] BIT_Z = FLAG_W'(1) << FLAG_Z;
    localparam logic [FLAG_W-1:0] BIT_C = FLAG_W'(1) << FLAG_C;
    localparam logic [FLAG_W-1:0] BIT_O = FLAG_W'(1) << FLAG_O;
    localparam logic [FLAG_W-1:0] BIT_S = FLAG_W'(1) << FLAG_S;

    // Which execution unit serves an operation code.
    function automatic alu_cls_e op_class(input logic [3:0] op);
        case (op)
            OP_AND, OP_OR, OP_XOR:                  return CLS_LOGIC;
            OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC: return CLS_ARITH;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_BIT: return CLS_SHIFT;
            default:                                return CLS_NONE;
        endcase
    endfunction

    // Flags an operation is allowed to change.
    function automatic logic [FLAG_W-1:0] op_mask(input logic [3:0] op);
        case (op)
            OP_AND, OP_OR, OP_XOR:                  return BIT_Z | BIT_S;
            OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC: return BIT_Z | BIT_C | BIT_O | BIT_S;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR:         return BIT_Z | BIT_C | BIT_S;
            OP_BIT:                                 return BIT_Z;
            default:                                return '0;
        endcase
    endfunction

    // Whether the result is meant for write-back.
    function automatic logic op_writes(input logic [3:0] op);
        return (op_class(op) != CLS_NONE) && (op != OP_CMP) && (op != OP_BIT);
    endfunction

endpackage

// File: rtl/alu8_logic_unit.sv
// Bitwise unit: AND, OR, XOR of the operands, zero-extended to the double
// width intermediate. Assumes op_sel is one of the logic codes when selected.
module alu8_logic_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WIDE_W = 2 * DATA_W
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [WIDE_W-1:0] wide_o
);
    // Pick the bitwise function.
    always_comb begin
        case (op_sel)
            OP_OR:   wide_o = WIDE_W'(opnd_a | opnd_b);
            OP_XOR:  wide_o = WIDE_W'(opnd_a ^ opnd_b);
            default: wide_o = WIDE_W'(opnd_a & opnd_b);
        endcase
    end
endmodule

// File: rtl/alu8_arith_unit.sv
// Arithmetic unit: add, subtract/compare, increment, decrement in double
// width so that a carry or a borrow lands in the upper half.
module alu8_arith_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WIDE_W = 2 * DATA_W
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [WIDE_W-1:0] wide_o
);
    logic [WIDE_W-1:0] a_w;
    logic [WIDE_W-1:0] b_w;

    assign a_w = WIDE_W'(opnd_a);
    assign b_w = WIDE_W'(opnd_b);

    // Form the wrapped double-width sum or difference.
    always_comb begin
        case (op_sel)
            OP_ADD:         wide_o = a_w + b_w;
            OP_SUB, OP_CMP: wide_o = a_w - b_w;
            OP_INC:         wide_o = a_w + WIDE_W'(1);
            default:        wide_o = a_w - WIDE_W'(1);
        endcase
    end
endmodule

// File: rtl/alu8_shift_unit.sv
// Shift, rotate and bit-test unit. The count/index is the low bits of
// opnd_b. Bits pushed past the top appear in the upper half of the
// intermediate; BIT yields the tested bit alone so that Z = not bit.
module alu8_shift_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WIDE_W = 2 * DATA_W,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [WIDE_W-1:0] wide_o
);
    logic [SHAMT_W-1:0] amt;
    logic [SHAMT_W:0]   inv_amt;
    logic [WIDE_W-1:0]  a_w;

    assign amt     = opnd_b[SHAMT_W-1:0];
    assign inv_amt = (SHAMT_W+1)'(DATA_W) - {1'b0, amt};
    assign a_w     = WIDE_W'(opnd_a);

    // Select shift, rotate or bit-test intermediate.
    always_comb begin
        case (op_sel)
            OP_SHL:  wide_o = a_w << amt;
            OP_SHR:  wide_o = a_w >> amt;
            OP_ROL:  wide_o = (a_w << amt) | (a_w >> inv_amt);
            OP_ROR:  wide_o = (a_w >> amt) | (a_w << inv_amt);
            default: wide_o = WIDE_W'(opnd_a[amt]);
        endcase
    end
endmodule

// File: rtl/alu8_flag_merge.sv
// Derives Z, C, O, S from the double-width intermediate and merges them
// into the incoming flags under a mask; unmasked bits pass straight through.
module alu8_flag_merge
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WIDE_W = 2 * DATA_W
) (
    input  logic [WIDE_W-1:0] wide_i,
    input  logic [FLAG_W-1:0] mask_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [FLAG_W-1:0] flags_o
);
    localparam logic [WIDE_W-1:0] LOW_MAX = WIDE_W'({DATA_W{1'b1}});

    logic [FLAG_W-1:0] calc;

    // Build the candidate condition flags.
    always_comb begin
        calc         = '0;
        calc[FLAG_Z] = (wide_i[DATA_W-1:0] == '0);
        calc[FLAG_C] = |wide_i[WIDE_W-1:DATA_W];
        calc[FLAG_O] = (wide_i > LOW_MAX);
        calc[FLAG_S] = wide_i[DATA_W-1];
    end

    // Keep unmasked flags, replace masked ones.
    assign flags_o = (flags_i & ~mask_i) | (calc & mask_i);
endmodule

// File: rtl/alu8_core.sv
// Top of the ALU: routes the operation to its unit, selects the
// intermediate, and applies the per-operation flag mask. Fully
// combinational; no clock or reset, no internal state.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int WIDE_W = 2 * DATA_W;

    logic [WIDE_W-1:0] logic_w;
    logic [WIDE_W-1:0] arith_w;
    logic [WIDE_W-1:0] shift_w;
    logic [WIDE_W-1:0] sel_w;
    alu_cls_e          cls;

    alu8_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .wide_o(logic_w)
    );

    alu8_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .wide_o(arith_w)
    );

    alu8_shift_unit #(.DATA_W(DATA_W)) u_shift (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .wide_o(shift_w)
    );

    assign cls = op_class(op_sel);

    // Choose the intermediate of the unit serving this code.
    always_comb begin
        case (cls)
            CLS_LOGIC: sel_w = logic_w;
            CLS_ARITH: sel_w = arith_w;
            CLS_SHIFT: sel_w = shift_w;
            default:   sel_w = '0;
        endcase
    end

    // Result is the low half, except BIT which hands the operand back.
    assign result_o = (op_sel == OP_BIT) ? opnd_a : sel_w[DATA_W-1:0];
    assign wr_en_o  = op_writes(op_sel);

    alu8_flag_merge #(.DATA_W(DATA_W)) u_flags (
        .wide_i(sel_w), .mask_i(op_mask(op_sel)), .flags_i(flags_in), .flags_o(flags_o)
    );
endmodule

// File: rtl/alu8_core_chk.sv
// Checker for alu8_core: immediate assertions on port relations,
// evaluated whenever inputs are known. Bound into every alu8_core.
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [FLAG_W-1:0] flags_in,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic [FLAG_W-1:0] flags_o
);
    alu_cls_e cls;
    logic     known;

    assign cls   = op_class(op_sel);
    assign known = !$isunknown({op_sel, opnd_a, opnd_b, flags_in});

    // Port-level invariants of the flag merge and write-back.
    always_comb begin
        if (known) begin
            p_upper_flags_r1: assert (flags_o[FLAG_W-1:4] == flags_in[FLAG_W-1:4]);
            if (cls == CLS_LOGIC)
                p_logic_keep_co_r2: assert (flags_o[2:1] == flags_in[2:1]);
            if (cls == CLS_ARITH)
                p_carry_eq_ovf_r3: assert (flags_o[FLAG_C] == flags_o[FLAG_O]);
            if (op_sel == OP_CMP)
                p_cmp_no_wb_r5: assert (!wr_en_o);
            if (wr_en_o && cls != CLS_NONE) begin
                p_zero_tracks_result_r6: assert (flags_o[FLAG_Z] == (result_o == '0));
                p_sign_tracks_result_r6: assert (flags_o[FLAG_S] == result_o[DATA_W-1]);
            end
            if (op_sel == OP_SHR)
                p_shr_clears_c_r7: assert (!flags_o[FLAG_C]);
            if (op_sel == OP_BIT)
                p_bit_only_z_r10: assert (flags_o[FLAG_W-1:1] == flags_in[FLAG_W-1:1] && !wr_en_o);
            if (cls == CLS_NONE)
                p_unassigned_inert_r11: assert (flags_o == flags_in && !wr_en_o);
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) chk_i (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
);

// File: tb/alu8_core_tb_top.sv
// Bench for alu8_core: vector table walk, then directed sweeps.
module alu8_core_tb_top;

    typedef struct packed {
        logic [3:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] fin;
        logic [7:0] res;
        logic       we;
        logic [7:0] fout;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  8'hF0, 8'h3C, 8'h00, 8'h30, 1'b1, 8'h00, 4'd2},  // R2 AND
        '{4'd0,  8'hF0, 8'h0F, 8'h06, 8'h00, 1'b1, 8'h07, 4'd2},  // R2 C,O kept
        '{4'd1,  8'h80, 8'h01, 8'h31, 8'h81, 1'b1, 8'h38, 4'd1},  // R1 I,B kept
        '{4'd2,  8'hAA, 8'hAA, 8'hC8, 8'h00, 1'b1, 8'hC1, 4'd1},  // R1 bits 7:6
        '{4'd3,  8'hFF, 8'h01, 8'h00, 8'h00, 1'b1, 8'h07, 4'd3},  // R3 carry
        '{4'd3,  8'h40, 8'h40, 8'h07, 8'h80, 1'b1, 8'h08, 4'd3},  // R3 no carry
        '{4'd4,  8'h05, 8'h03, 8'h0F, 8'h02, 1'b1, 8'h00, 4'd4},  // R4
        '{4'd4,  8'h03, 8'h05, 8'h00, 8'hFE, 1'b1, 8'h0E, 4'd4},  // R4 borrow
        '{4'd5,  8'h10, 8'h10, 8'h10, 8'h00, 1'b0, 8'h11, 4'd5},  // R5 equal
        '{4'd5,  8'h00, 8'h01, 8'h00, 8'hFF, 1'b0, 8'h0E, 4'd5},  // R5 borrow
        '{4'd6,  8'hFF, 8'h55, 8'h00, 8'h00, 1'b1, 8'h07, 4'd3},  // R3 INC
        '{4'd7,  8'h00, 8'h55, 8'h01, 8'hFF, 1'b1, 8'h0E, 4'd4},  // R4 DEC wrap
        '{4'd7,  8'h01, 8'h00, 8'h0E, 8'h00, 1'b1, 8'h01, 4'd6},  // R6 zero
        '{4'd8,  8'h81, 8'h01, 8'h04, 8'h02, 1'b1, 8'h06, 4'd7},  // R7 SHL out
        '{4'd8,  8'h01, 8'hF9, 8'h00, 8'h02, 1'b1, 8'h00, 4'd7},  // R7 B[7:3] ignored
        '{4'd9,  8'h81, 8'h03, 8'h02, 8'h10, 1'b1, 8'h00, 4'd7},  // R7 SHR clears C
        '{4'd9,  8'h01, 8'h01, 8'h00, 8'h00, 1'b1, 8'h01, 4'd7},  // R7 to zero
        '{4'd10, 8'h81, 8'h01, 8'h00, 8'h03, 1'b1, 8'h02, 4'd8},  // R8 ROL
        '{4'd10, 8'h81, 8'h00, 8'h02, 8'h81, 1'b1, 8'h08, 4'd8},  // R8 count 0
        '{4'd11, 8'h01, 8'h01, 8'h00, 8'h80, 1'b1, 8'h08, 4'd9},  // R9 ROR
        '{4'd11, 8'h81, 8'h00, 8'h00, 8'h81, 1'b1, 8'h0A, 4'd9},  // R9 count 0
        '{4'd11, 8'h02, 8'h01, 8'h00, 8'h01, 1'b1, 8'h02, 4'd9},  // R9 C set
        '{4'd12, 8'h08, 8'h03, 8'h0E, 8'h08, 1'b0, 8'h0E, 4'd10}, // R10 bit=1
        '{4'd12, 8'h08, 8'h02, 8'h3E, 8'h08, 1'b0, 8'h3F, 4'd10}, // R10 bit=0
        '{4'd13, 8'hFF, 8'hFF, 8'hA5, 8'h00, 1'b0, 8'hA5, 4'd11}, // R11
        '{4'd15, 8'h12, 8'h34, 8'h5A, 8'h00, 1'b0, 8'h5A, 4'd11}  // R11
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [7:0] flags_in = '0;
    logic [7:0] result_o;
    logic       wr_en_o;
    logic [7:0] flags_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alu8_core dut_i (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    task automatic drive(input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] f);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; flags_in = f;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got res/we/flags %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R2: quiet inputs give AND result 0 with Z set and nothing else
        drive(4'd0, 8'h00, 8'h00, 8'h00);
        check("R2 idle", {result_o, wr_en_o, flags_o}, {8'h00, 1'b1, 8'h01});
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].fin);
            check($sformatf("R%0d vec %0d", VECS[i].req, i), {result_o, wr_en_o, flags_o},
                  {VECS[i].res, VECS[i].we, VECS[i].fout});
        end
        // R8: every rotate-left count, carry from bits wrapped around
        for (int n = 0; n < 8; n++) begin
            logic [7:0] a, r;
            logic c;
            a = 8'hB3;
            r = (n == 0) ? a : ((a << n) | (a >> (8 - n)));
            c = (n == 0) ? 1'b0 : |(a >> (8 - n));
            drive(4'd10, a, 8'(n) | 8'hF8, 8'h04);
            check($sformatf("R8 rol n=%0d", n), {result_o, wr_en_o, flags_o},
                  {r, 1'b1, {4'h0, r[7], 1'b1, c, (r == 8'h00)}});
        end
        // R9: every rotate-right count, carry from A shifted right by n
        for (int n = 0; n < 8; n++) begin
            logic [7:0] a, r;
            logic c;
            a = 8'h4C;
            r = (n == 0) ? a : ((a >> n) | (a << (8 - n)));
            c = |(a >> n);
            drive(4'd11, a, 8'(n), 8'h30);
            check($sformatf("R9 ror n=%0d", n), {result_o, wr_en_o, flags_o},
                  {r, 1'b1, {4'h3, r[7], 1'b0, c, (r == 8'h00)}});
        end
        // R10: every bit index of a pattern
        for (int n = 0; n < 8; n++) begin
            logic [7:0] a;
            a = 8'h5A;
            drive(4'd12, a, 8'(n), 8'hFE);
            check($sformatf("R10 bit %0d", n), {result_o, wr_en_o, flags_o},
                  {a, 1'b0, 7'h7F, ~a[n]});
        end
        // R12 / R11: write-back enable over all codes
        for (int k = 0; k < 16; k++) begin
            logic exp_we;
            exp_we = (k <= 4) || (k >= 6 && k <= 11);
            drive(4'(k), 8'h3C, 8'h01, 8'hC0);
            check($sformatf("R12 we code %0d", k), {16'h0, wr_en_o}, {16'h0, exp_we});
        end
        done = 1;
    end

    initial begin
        for (int cyc = 0; cyc < 5000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no completion expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule